// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss in hardware. It takes a 32-bit virtual address, the kind of access that missed, and the current root table pointer. It then reads two page-table entries in turn from memory: first the entry in the root table, then the leaf entry in the second-level table that the first entry points at. Both reads go through a simple read port that allows only one read in flight. No exception is taken along the way unless the mapping is missing.

The walk ends in one of two ways. It can finish with a one-cycle completion pulse that carries the leaf entry, the physical address, the protection and memory-type fields and the virtual page number, which is everything a TLB refill needs. It can also finish with a one-cycle fault pulse whose code tells apart three cases: a missing second-level table, a page that does not exist, and a page that exists but is held in secondary storage. Setting accessed or dirty bits and handling faults are left to the surrounding system.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and directly after it is released, req_ready_o is 1, mem_req_o is 0, done_o and fault_o are 0, and fault_code_o is 0.
- R2: The first memory read of a walk uses the address root + 4 * va[31:22]. Both root and va are captured in the cycle the request is accepted.
- R3: The second memory read uses the address {E1[31:12], 12'h000} + 4 * va[21:12], where E1 is the first-level entry that was read.
- R4: mem_req_o and mem_addr_o stay unchanged until mem_gnt_i is seen. After a grant, no new request is raised until mem_rvalid_i returns the data.
- R5: If bit 0 (valid) of the first-level entry is 0, the walk ends with fault code 1, and no second read is made.
- R6: If bit 0 (valid) of the leaf entry is 0, the walk ends with fault code 2.
- R7: If the leaf entry has bit 0 set to 1 and bit 1 (resident) set to 0, the walk ends with fault code 3.
- R8: If the leaf entry has bits 0 and 1 both set to 1, done_o rises. At the same time rsp_pte_o equals the leaf entry, rsp_pa_o = {leaf[31:12], va[11:0]}, rsp_perm_o = leaf[4:2], rsp_mtype_o = leaf[6:5], rsp_vpn_o = va[31:12], and rsp_acc_o is the access type captured at acceptance.
- R9: done_o and fault_o are never high together. Each is high for exactly one cycle, and req_ready_o is 1 in the cycle after.
- R10: A request is accepted only while req_ready_o is 1. req_ready_o is 0 from the cycle after acceptance until the result pulse. Changes to req_va_i, req_acc_i and root_base_i during a walk have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker is idle and takes a request |
| req_va_i | input | 32 | Virtual address that missed |
| req_acc_i | input | 2 | Access type, passed through to the result |
| root_base_i | input | 32 | Byte address of the first-level table |
| mem_req_o | output | 1 | Memory read request |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | Translation complete pulse |
| rsp_pte_o | output | 32 | Leaf entry |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_vpn_o | output | 20 | Virtual page number of the walk |
| rsp_perm_o | output | 3 | Protection field of the leaf |
| rsp_mtype_o | output | 2 | Memory-type field of the leaf |
| rsp_acc_o | output | 2 | Access type of the walk |
| fault_o | output | 1 | Walk fault pulse |
| fault_code_o | output | 2 | 1 no table, 2 no page, 3 not resident; 0 when fault_o is low |

## Verification
The bench builds the walker with its default parameters: a 10/10/12 address split, 32-bit entries and a 32-bit physical space. This makes full-width corner addresses reachable, such as all-ones and all-zeros virtual addresses and a first-level index of 1023 added to a root near its top. The memory model stalls grants and read data at random, so the hold and single-outstanding rules are exercised with both short and long waits. A directed run changes the address, access type and root while a walk is in progress, and an unmapped root table is used to reach the first-level fault through memory that was never written.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  // entry field positions, decoded by the TLB as well
  localparam int PTE_VALID    = 0;
  localparam int PTE_RES      = 1;
  localparam int PTE_PERM_LSB = 2;
  localparam int PTE_PERM_W   = 3;
  localparam int PTE_MT_LSB   = 5;
  localparam int PTE_MT_W     = 2;

  localparam int FLT_W = 2;
  localparam logic [FLT_W-1:0] FLT_NONE    = 2'd0;
  localparam logic [FLT_W-1:0] FLT_L1_INV  = 2'd1;
  localparam logic [FLT_W-1:0] FLT_L2_INV  = 2'd2;
  localparam logic [FLT_W-1:0] FLT_NOT_RES = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_va_split.sv
`timescale 1ns/1ps
module ptw_va_split #(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  localparam int OFF_W   = VA_W - L1_IDX_W - L2_IDX_W
) (
  input  logic [VA_W-1:0]     va_i,
  output logic [L1_IDX_W-1:0] idx1_o,
  output logic [L2_IDX_W-1:0] idx2_o,
  output logic [OFF_W-1:0]    off_o
);
  assign idx1_o = va_i[VA_W-1 -: L1_IDX_W];
  assign idx2_o = va_i[OFF_W +: L2_IDX_W];
  assign off_o  = va_i[OFF_W-1:0];
endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int OFF_W    = 12,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int PTE_SH  = $clog2(PTE_W / 8)
) (
  input  logic [PA_W-1:0]     root_i,
  input  logic [L1_IDX_W-1:0] idx1_i,
  input  logic [L2_IDX_W-1:0] idx2_i,
  input  logic [FRAME_W-1:0]  l2_frame_i,
  input  logic                l2_sel_i,
  output logic [PA_W-1:0]     addr_o
);
  logic [PA_W-1:0] l1_off, l2_off, l2_base, l1_addr, l2_addr;

  assign l1_off  = PA_W'(idx1_i) << PTE_SH;
  assign l2_off  = PA_W'(idx2_i) << PTE_SH;
  assign l2_base = {l2_frame_i, {OFF_W{1'b0}}};
  assign l1_addr = root_i + l1_off;
  assign l2_addr = l2_base + l2_off;
  assign addr_o  = l2_sel_i ? l2_addr : l1_addr;
endmodule

// File: rtl/ptw_ctrl.sv
`timescale 1ns/1ps
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int ACC_W    = 2,
  parameter int OFF_W    = 12,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic [ACC_W-1:0]   req_acc_i,
  input  logic [PA_W-1:0]    root_base_i,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [PTE_W-1:0]   mem_rdata_i,
  output logic               req_ready_o,
  output logic               mem_req_o,
  output logic               l2_sel_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [FLT_W-1:0]   fault_code_o,
  output logic [VA_W-1:0]    va_o,
  output logic [ACC_W-1:0]   acc_o,
  output logic [PA_W-1:0]    root_o,
  output logic [FRAME_W-1:0] l2_frame_o,
  output logic [PTE_W-1:0]   leaf_o
);
  walk_st_e            state_q, state_d;
  logic [VA_W-1:0]     va_q;
  logic [ACC_W-1:0]    acc_q;
  logic [PA_W-1:0]     root_q;
  logic [FRAME_W-1:0]  l2_frame_q;
  logic [PTE_W-1:0]    leaf_q;
  logic [FLT_W-1:0]    flt_q, flt_d;
  logic                rd_valid, rd_res;

  assign rd_valid = mem_rdata_i[PTE_VALID];
  assign rd_res   = mem_rdata_i[PTE_RES];

  always_comb begin
    state_d = state_q;
    flt_d   = flt_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_gnt_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) begin
        if (!rd_valid) begin
          state_d = ST_FAULT;
          flt_d   = FLT_L1_INV;
        end else begin
          state_d = ST_L2_REQ;
        end
      end
      ST_L2_REQ:  if (mem_gnt_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid_i) begin
        if (!rd_valid) begin
          state_d = ST_FAULT;
          flt_d   = FLT_L2_INV;
        end else if (!rd_res) begin
          state_d = ST_FAULT;
          flt_d   = FLT_NOT_RES;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      acc_q      <= '0;
      root_q     <= '0;
      l2_frame_q <= '0;
      leaf_q     <= '0;
      flt_q      <= FLT_NONE;
    end else begin
      state_q <= state_d;
      flt_q   <= flt_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        va_q   <= req_va_i;
        acc_q  <= req_acc_i;
        root_q <= root_base_i;
      end
      if (state_q == ST_L1_WAIT && mem_rvalid_i)
        l2_frame_q <= mem_rdata_i[PTE_W-1 -: FRAME_W];
      if (state_q == ST_L2_WAIT && mem_rvalid_i)
        leaf_q <= mem_rdata_i;
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign l2_sel_o     = (state_q == ST_L2_REQ);
  assign done_o       = (state_q == ST_DONE);
  assign fault_o      = (state_q == ST_FAULT);
  assign fault_code_o = fault_o ? flt_q : FLT_NONE;
  assign va_o         = va_q;
  assign acc_o        = acc_q;
  assign root_o       = root_q;
  assign l2_frame_o   = l2_frame_q;
  assign leaf_o       = leaf_q;
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  parameter int ACC_W    = 2,
  localparam int OFF_W   = VA_W - L1_IDX_W - L2_IDX_W,
  localparam int VPN_W   = L1_IDX_W + L2_IDX_W,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_va_i,
  input  logic [ACC_W-1:0]      req_acc_i,
  input  logic [PA_W-1:0]       root_base_i,
  output logic                  mem_req_o,
  input  logic                  mem_gnt_i,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [PTE_W-1:0]      mem_rdata_i,
  output logic                  done_o,
  output logic [PTE_W-1:0]      rsp_pte_o,
  output logic [PA_W-1:0]       rsp_pa_o,
  output logic [VPN_W-1:0]      rsp_vpn_o,
  output logic [PTE_PERM_W-1:0] rsp_perm_o,
  output logic [PTE_MT_W-1:0]   rsp_mtype_o,
  output logic [ACC_W-1:0]      rsp_acc_o,
  output logic                  fault_o,
  output logic [FLT_W-1:0]      fault_code_o
);
  logic [VA_W-1:0]     va_q;
  logic [PA_W-1:0]     root_q;
  logic [FRAME_W-1:0]  l2_frame_q;
  logic [PTE_W-1:0]    leaf_q;
  logic                l2_sel;
  logic [L1_IDX_W-1:0] idx1;
  logic [L2_IDX_W-1:0] idx2;
  logic [OFF_W-1:0]    off;

  ptw_ctrl #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .PTE_W(PTE_W),
    .ACC_W(ACC_W),
    .OFF_W(OFF_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_va_i    (req_va_i),
    .req_acc_i   (req_acc_i),
    .root_base_i (root_base_i),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .req_ready_o (req_ready_o),
    .mem_req_o   (mem_req_o),
    .l2_sel_o    (l2_sel),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .fault_code_o(fault_code_o),
    .va_o        (va_q),
    .acc_o       (rsp_acc_o),
    .root_o      (root_q),
    .l2_frame_o  (l2_frame_q),
    .leaf_o      (leaf_q)
  );

  ptw_va_split #(
    .VA_W    (VA_W),
    .L1_IDX_W(L1_IDX_W),
    .L2_IDX_W(L2_IDX_W)
  ) u_split (
    .va_i  (va_q),
    .idx1_o(idx1),
    .idx2_o(idx2),
    .off_o (off)
  );

  ptw_addr_gen #(
    .PA_W    (PA_W),
    .PTE_W   (PTE_W),
    .OFF_W   (OFF_W),
    .L1_IDX_W(L1_IDX_W),
    .L2_IDX_W(L2_IDX_W)
  ) u_addr (
    .root_i    (root_q),
    .idx1_i    (idx1),
    .idx2_i    (idx2),
    .l2_frame_i(l2_frame_q),
    .l2_sel_i  (l2_sel),
    .addr_o    (mem_addr_o)
  );

  assign rsp_pte_o   = leaf_q;
  assign rsp_pa_o    = {leaf_q[PTE_W-1 -: FRAME_W], off};
  assign rsp_vpn_o   = {idx1, idx2};
  assign rsp_perm_o  = leaf_q[PTE_PERM_LSB +: PTE_PERM_W];
  assign rsp_mtype_o = leaf_q[PTE_MT_LSB +: PTE_MT_W];
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk
  import ptw_pkg::*;
#(
  parameter int PA_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             mem_req_o,
  input logic             mem_gnt_i,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             mem_rvalid_i,
  input logic             done_o,
  input logic             fault_o,
  input logic [FLT_W-1:0] fault_code_o
);
  logic       outst_q;
  logic [1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q  <= 1'b0;
      rd_cnt_q <= '0;
    end else begin
      if (mem_req_o && mem_gnt_i) outst_q <= 1'b1;
      else if (mem_rvalid_i)      outst_q <= 1'b0;
      if (req_valid_i && req_ready_o) rd_cnt_q <= '0;
      else if (mem_rvalid_i && rd_cnt_q != 2'd3) rd_cnt_q <= rd_cnt_q + 2'd1;
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (req_ready_o && !mem_req_o && !done_o && !fault_o);
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  // R4
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_o);

  // R5
  l1_fault_single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_code_o == FLT_L1_INV |-> rd_cnt_q == 2'd1);

  // R8
  done_two_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_cnt_q == 2'd2);

  // R9
  done_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  // R9
  pulse_then_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o || fault_o |=> req_ready_o && !done_o && !fault_o);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .fault_code_o(fault_code_o)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic [31:0] root_base_i = '0;
  logic        mem_req_o;
  logic        mem_gnt_i;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        done_o;
  logic [31:0] rsp_pte_o;
  logic [31:0] rsp_pa_o;
  logic [19:0] rsp_vpn_o;
  logic [2:0]  rsp_perm_o;
  logic [1:0]  rsp_mtype_o;
  logic [1:0]  rsp_acc_o;
  logic        fault_o;
  logic [1:0]  fault_code_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem_q [logic [31:0]];
  logic [31:0] rd_addr [4];
  int          rd_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_va_i    (req_va_i),
    .req_acc_i   (req_acc_i),
    .root_base_i (root_base_i),
    .mem_req_o   (mem_req_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .rsp_pte_o   (rsp_pte_o),
    .rsp_pa_o    (rsp_pa_o),
    .rsp_vpn_o   (rsp_vpn_o),
    .rsp_perm_o  (rsp_perm_o),
    .rsp_mtype_o (rsp_mtype_o),
    .rsp_acc_o   (rsp_acc_o),
    .fault_o     (fault_o),
    .fault_code_o(fault_code_o)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // memory model: random grant stall and read latency, one read at a time
  initial begin
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          lat = 0;
    mem_gnt_i    = 1'b0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    forever begin
      @(negedge clk);
      mem_gnt_i    = 1'b0;
      mem_rvalid_i = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_rd(pend_addr);
          pend = 1'b0;
        end else begin
          lat--;
        end
      end else if (mem_req_o && ($urandom % 3) != 0) begin
        mem_gnt_i = 1'b1;
        pend      = 1'b1;
        pend_addr = mem_addr_o;
        lat       = $urandom % 4;
        if (rd_n < 4) rd_addr[rd_n] = mem_addr_o;
        rd_n++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input logic [1:0] acc, input bit busy);
    logic [31:0] l1a, p1, l2a, p2, exp_pa;
    logic [1:0]  exp_code;
    int          exp_rd;
    bit          exp_done, ready_bad;
    int          n;
    l1a = root + {20'h0, va[31:22], 2'b00};
    p1  = mem_rd(l1a);
    l2a = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    p2  = mem_rd(l2a);
    exp_done = 1'b0;
    exp_code = 2'd0;
    exp_rd   = 2;
    if (!p1[0]) begin
      exp_code = 2'd1;
      exp_rd   = 1;
    end else if (!p2[0]) exp_code = 2'd2;
    else if (!p2[1]) exp_code = 2'd3;
    else exp_done = 1'b1;
    exp_pa = {p2[31:12], va[11:0]};

    rd_n = 0;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_va_i    = va;
    req_acc_i   = acc;
    root_base_i = root;
    @(negedge clk);
    if (busy) begin
      req_va_i    = va ^ 32'hA5A5_5A5A;
      req_acc_i   = ~acc;
      root_base_i = root ^ 32'h0000_1000;
    end else begin
      req_valid_i = 1'b0;
    end
    ready_bad = 1'b0;
    n = 0;
    while (!(done_o || fault_o) && n < 300) begin
      if (req_ready_o) ready_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    req_valid_i = 1'b0;
    // R10
    check(!ready_bad, "R10 ready low while busy", {63'h0, ready_bad}, 64'h0);
    // R2
    check(rd_n >= 1 && rd_addr[0] == l1a, "R2 first read address", rd_addr[0], l1a);
    if (exp_rd == 2) begin
      // R3
      check(rd_n == 2 && rd_addr[1] == l2a, "R3 second read address", rd_addr[1], l2a);
    end else begin
      // R5
      check(rd_n == 1, "R5 no second read", rd_n, 1);
    end
    if (exp_done) begin
      // R8
      check(done_o && !fault_o, "R8 done pulse", {fault_o, done_o}, 2'b01);
      check(rsp_pte_o == p2 && rsp_pa_o == exp_pa, "R8 leaf and pa", {rsp_pte_o, rsp_pa_o}, {p2, exp_pa});
      check(rsp_perm_o == p2[4:2] && rsp_mtype_o == p2[6:5], "R8 perm and mtype",
            {rsp_perm_o, rsp_mtype_o}, {p2[4:2], p2[6:5]});
      check(rsp_vpn_o == va[31:12] && rsp_acc_o == acc, "R8 vpn and access",
            {rsp_vpn_o, rsp_acc_o}, {va[31:12], acc});
    end else begin
      // R5 R6 R7
      check(fault_o && !done_o && fault_code_o == exp_code,
            exp_code == 2'd1 ? "R5 l1 fault" : (exp_code == 2'd2 ? "R6 leaf fault" : "R7 not resident"),
            {fault_o, done_o, fault_code_o}, {2'b10, exp_code});
    end
    @(negedge clk);
    // R9
    check(!done_o && !fault_o && req_ready_o && fault_code_o == 2'd0, "R9 single pulse then ready",
          {done_o, fault_o, req_ready_o}, 3'b001);
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] root, input int mode);
    logic [31:0] p1, p2, l1a, l2a;
    mem_q.delete();
    p1 = $urandom;
    p1[31] = 1'b1;
    p1[0]  = (mode != 0);
    p2 = $urandom;
    p2[0] = (mode >= 2);
    p2[1] = (mode >= 3);
    l1a = root + {20'h0, va[31:22], 2'b00};
    l2a = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    mem_q[l1a] = p1;
    mem_q[l2a] = p2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] va, root;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R1
    check(req_ready_o && !mem_req_o && !done_o && !fault_o && fault_code_o == 2'd0,
          "R1 reset state", {req_ready_o, mem_req_o, done_o, fault_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready_o && !mem_req_o && !done_o && !fault_o, "R1 after release",
          {req_ready_o, mem_req_o, done_o, fault_o}, 4'b1000);

    // unmapped root table reads zero: R5
    mem_q.delete();
    walk(32'h1234_5678, 32'h1000_0000, 2'd0, 1'b0);
    // top corner of both indices, full mapping: R2 R3 R8
    fill(32'hFFFF_FFFF, 32'h1FFF_F000, 3);
    walk(32'hFFFF_FFFF, 32'h1FFF_F000, 2'd2, 1'b0);
    fill(32'h0000_0000, 32'h1000_0000, 3);
    walk(32'h0000_0000, 32'h1000_0000, 2'd1, 1'b0);
    // R6 R7 directed
    fill(32'h0040_3ABC, 32'h1234_5000, 1);
    walk(32'h0040_3ABC, 32'h1234_5000, 2'd0, 1'b0);
    fill(32'h8000_1FFF, 32'h1234_5000, 2);
    walk(32'h8000_1FFF, 32'h1234_5000, 2'd1, 1'b0);
    // inputs change while busy: R10
    fill(32'hCAFE_B123, 32'h1555_0000, 3);
    walk(32'hCAFE_B123, 32'h1555_0000, 2'd2, 1'b1);
    fill(32'h3C3C_3C3C, 32'h1AAA_0000, 2);
    walk(32'h3C3C_3C3C, 32'h1AAA_0000, 2'd1, 1'b1);

    for (int i = 0; i < 80; i++) begin
      int mode;
      va   = $urandom;
      root = {4'h1, 26'($urandom), 2'b00};
      mode = ($urandom % 6);
      if (mode > 3) mode = 3;
      fill(va, root, mode);
      walk(va, root, 2'($urandom % 3), ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule